// File: doc/BRIEF.md
# Speculative context snapshot manager

This block holds the internal accumulator of a stateful function unit that sits inside an out-of-order core. Instructions reach it in program order. Each one reads, adds to, overwrites or conditionally increments the accumulator, and each returns the updated value to its destination one cycle later. Only the live execution copy is ever visible through results.

Two lagging copies make misspeculation recoverable without a checkpoint per instruction. A commit counter periodically copies the live value into a speculative snapshot. That snapshot is tagged with the youngest instruction that had executed when it was taken. When that owner instruction commits, the snapshot is promoted to the committed copy. The committed owner tag is published so that an external instruction log can prune itself.

On a kill, the block stalls issue and loads the live value from the committed copy. It then applies the log entries that the external log streams back: only those younger than the committed owner and older than the killed instruction. Tags are 8-bit sequence numbers compared modulo 256.

The control is a three-state machine:
- RUN: normal issue.
- RESTORE: one cycle, live copy loaded from the committed copy.
- REPLAY: log entries applied until the log signals its end.

Transitions:
- kill_seen: RUN to RESTORE.
- restore_done: RESTORE to REPLAY, unconditional.
- replay_end: REPLAY to RUN, on rep_done.

Top module: `spec_ctx_mgr`

## Requirements
- R1: After reset, iss_ready is 1, busy is 0, replay_start is 0, res_valid is 0 and cmt_owner_valid is 0, and a read returns 0.
- R2: iss_op encodes 0 read, 1 add iss_src, 2 set to iss_src, 3 add one when iss_src is nonzero (else no change); all arithmetic wraps modulo 2^DATA_W. An accepted instruction yields res_valid for exactly one cycle on the next cycle, carrying its tag, its dest and the accumulator value after its own update.
- R3: In RUN, each commit message advances a counter. On the SNAP_K-th message the counter returns to zero, the live value is copied into the speculative snapshot, and the snapshot owner becomes the tag of the last executed instruction.
- R4: A commit whose tag equals the pending snapshot owner promotes the snapshot to the committed copy. cmt_owner then takes that tag and cmt_owner_valid goes to 1. When a snapshot is taken in the same cycle as a commit, the snapshot is taken first and then the match is tested.
- R5: A kill in RUN clears the commit counter and discards any pending snapshot. iss_ready is 0 in the cycle a kill is presented.
- R6: The cycle after a kill, busy and replay_start are 1 and the live value equals the committed copy (0 if nothing has committed yet). In the following cycle replay_start is 0 and busy stays 1.
- R7: During REPLAY, a log entry updates the accumulator with the R2 operations only if its tag is strictly older than the kill tag and, when cmt_owner_valid is 1, strictly younger than cmt_owner. Age is decided by the sign of the 8-bit difference. Replay produces no res_valid.
- R8: iss_ready is 0 while busy. The cycle after rep_done, busy is 0 and iss_ready is 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issued instruction present |
| iss_ready | output | 1 | Block accepts an instruction |
| iss_tag | input | 8 | Sequence tag of issued instruction |
| iss_op | input | 2 | Operation code |
| iss_src | input | DATA_W | Source operand |
| iss_dest | input | DEST_W | Return destination |
| res_valid | output | 1 | Result present |
| res_tag | output | 8 | Tag of the result |
| res_dest | output | DEST_W | Destination of the result |
| res_data | output | DATA_W | Accumulator value after the instruction |
| commit_valid | input | 1 | Commit message present |
| commit_tag | input | 8 | Tag of committed instruction |
| kill_valid | input | 1 | Misspeculation notice |
| kill_tag | input | 8 | Oldest discarded instruction |
| busy | output | 1 | Rollback in progress |
| replay_start | output | 1 | Pulse asking the log to stream entries |
| rep_valid | input | 1 | Log entry present |
| rep_tag | input | 8 | Tag of log entry |
| rep_op | input | 2 | Operation of log entry |
| rep_src | input | DATA_W | Source of log entry |
| rep_done | input | 1 | Log stream finished |
| cmt_owner | output | 8 | Tag owning the committed copy |
| cmt_owner_valid | output | 1 | Committed copy has an owner |

## Verification
A wrong snapshot, owner or counter stays hidden until a rollback. It then shows as a wrong value on the first read after busy falls, or as a cmt_owner that moves at the wrong commit on the cycle after that commit. A faulty replay filter or wraparound compare shows on the first read after recovery. The scenarios place the snapshot boundary, the owner match, the kill and the tag wrap at positions where each wrong choice gives a different read value.

// File: rtl/spec_ctx_pkg.sv
package spec_ctx_pkg;
    localparam int TAG_W = 8;
    typedef logic [TAG_W-1:0] tag_t;

    typedef enum logic [1:0] {
        OP_READ = 2'd0,
        OP_ADD  = 2'd1,
        OP_SET  = 2'd2,
        OP_CINC = 2'd3
    } ctx_op_e;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_RESTORE = 2'd1,
        ST_REPLAY  = 2'd2
    } rb_state_e;

    // a is older than b when a - b is negative in modular sequence space
    function automatic logic tag_older(tag_t a, tag_t b);
        tag_t d;
        d = a - b;
        return d[TAG_W-1];
    endfunction
endpackage

// File: rtl/spec_ctx_alu.sv
module spec_ctx_alu
    import spec_ctx_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [1:0]        op,
    input  logic [DATA_W-1:0] src,
    input  logic [DATA_W-1:0] cur,
    output logic [DATA_W-1:0] nxt
);
    localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

    always_comb begin
        unique case (ctx_op_e'(op))
            OP_READ: nxt = cur;
            OP_ADD:  nxt = cur + src;
            OP_SET:  nxt = src;
            OP_CINC: nxt = (src != '0) ? cur + ONE : cur;
            default: nxt = cur;
        endcase
    end
endmodule

// File: rtl/spec_ctx_snap.sv
module spec_ctx_snap
    import spec_ctx_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int SNAP_K = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              running,
    input  logic              commit_valid,
    input  tag_t              commit_tag,
    input  logic              kill_take,
    input  logic [DATA_W-1:0] live_val,
    input  tag_t              last_tag,
    input  logic              last_ok,
    output logic [DATA_W-1:0] cmt_val,
    output tag_t              cmt_tag,
    output logic              cmt_ok
);
    localparam int CNT_W = (SNAP_K > 1) ? $clog2(SNAP_K) : 1;
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(SNAP_K - 1);

    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] spec_q;
    tag_t              spec_tag_q;
    logic              pend_q;

    logic              snap_hit;
    logic              eff_pend;
    tag_t              eff_tag;
    logic [DATA_W-1:0] eff_val;
    logic              promote;

    assign snap_hit = running && commit_valid && !kill_take && (cnt_q == CNT_TOP);

    // snapshot applied first, owner match tested against the result
    always_comb begin
        if (snap_hit && last_ok) begin
            eff_pend = 1'b1;
            eff_tag  = last_tag;
            eff_val  = live_val;
        end else begin
            eff_pend = pend_q;
            eff_tag  = spec_tag_q;
            eff_val  = spec_q;
        end
    end

    assign promote = commit_valid && eff_pend && (eff_tag == commit_tag);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            spec_q     <= '0;
            spec_tag_q <= '0;
            pend_q     <= 1'b0;
            cmt_val    <= '0;
            cmt_tag    <= '0;
            cmt_ok     <= 1'b0;
        end else begin
            if (kill_take) begin
                cnt_q <= '0;
            end else if (running && commit_valid) begin
                cnt_q <= (cnt_q == CNT_TOP) ? '0 : cnt_q + 1'b1;
            end

            if (snap_hit && last_ok) begin
                spec_q     <= live_val;
                spec_tag_q <= last_tag;
            end

            if (promote) begin
                cmt_val <= eff_val;
                cmt_tag <= commit_tag;
                cmt_ok  <= 1'b1;
            end

            if (kill_take || promote) begin
                pend_q <= 1'b0;
            end else if (snap_hit && last_ok) begin
                pend_q <= 1'b1;
            end
        end
    end

    always_comb begin
        if (rst_n) begin
            assert_cnt_range_R3: assert (cnt_q <= CNT_TOP);
        end
    end

    assert_owner_moves_on_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cmt_tag) |-> $past(commit_valid));

    assert_kill_clears_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        kill_take |=> (cnt_q == '0) && !pend_q);
endmodule

// File: rtl/spec_ctx_fsm.sv
module spec_ctx_fsm
    import spec_ctx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      kill_valid,
    input  logic      rep_done,
    output rb_state_e state,
    output logic      running,
    output logic      busy,
    output logic      replay_start
);
    rb_state_e state_d;

    always_comb begin
        state_d = state;
        unique case (state)
            ST_RUN:     if (kill_valid) state_d = ST_RESTORE;
            ST_RESTORE: state_d = ST_REPLAY;
            ST_REPLAY:  if (rep_done) state_d = ST_RUN;
            default:    state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_d;
    end

    always_comb begin
        running      = 1'b0;
        busy         = 1'b1;
        replay_start = 1'b0;
        unique case (state)
            ST_RUN: begin
                running = 1'b1;
                busy    = 1'b0;
            end
            ST_RESTORE: replay_start = 1'b1;
            ST_REPLAY:  ;
            default: begin
                running = 1'b1;
                busy    = 1'b0;
            end
        endcase
    end

    assert_restore_single_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        replay_start |=> !replay_start && busy);

    assert_busy_ends_on_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(rep_done));
endmodule

// File: rtl/spec_ctx_mgr.sv
module spec_ctx_mgr
    import spec_ctx_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEST_W = 5,
    parameter int SNAP_K = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    output logic              iss_ready,
    input  logic [7:0]        iss_tag,
    input  logic [1:0]        iss_op,
    input  logic [DATA_W-1:0] iss_src,
    input  logic [DEST_W-1:0] iss_dest,
    output logic              res_valid,
    output logic [7:0]        res_tag,
    output logic [DEST_W-1:0] res_dest,
    output logic [DATA_W-1:0] res_data,
    input  logic              commit_valid,
    input  logic [7:0]        commit_tag,
    input  logic              kill_valid,
    input  logic [7:0]        kill_tag,
    output logic              busy,
    output logic              replay_start,
    input  logic              rep_valid,
    input  logic [7:0]        rep_tag,
    input  logic [1:0]        rep_op,
    input  logic [DATA_W-1:0] rep_src,
    input  logic              rep_done,
    output logic [7:0]        cmt_owner,
    output logic              cmt_owner_valid
);
    rb_state_e         state;
    logic              running;
    logic              kill_take;
    logic              issue_fire;
    logic              rep_apply;
    logic [DATA_W-1:0] live_q;
    tag_t              last_tag_q;
    logic              last_ok_q;
    tag_t              kill_tag_q;
    logic [DATA_W-1:0] cmt_val;
    logic [1:0]        alu_op;
    logic [DATA_W-1:0] alu_src;
    logic [DATA_W-1:0] alu_nxt;

    spec_ctx_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .kill_valid   (kill_valid),
        .rep_done     (rep_done),
        .state        (state),
        .running      (running),
        .busy         (busy),
        .replay_start (replay_start)
    );

    assign kill_take  = running && kill_valid;
    assign iss_ready  = running && !kill_valid;
    assign issue_fire = iss_valid && iss_ready;
    assign rep_apply  = (state == ST_REPLAY) && rep_valid
                        && tag_older(rep_tag, kill_tag_q)
                        && (!cmt_owner_valid || tag_older(cmt_owner, rep_tag));

    assign alu_op  = (state == ST_REPLAY) ? rep_op  : iss_op;
    assign alu_src = (state == ST_REPLAY) ? rep_src : iss_src;

    spec_ctx_alu #(.DATA_W(DATA_W)) u_alu (
        .op  (alu_op),
        .src (alu_src),
        .cur (live_q),
        .nxt (alu_nxt)
    );

    spec_ctx_snap #(.DATA_W(DATA_W), .SNAP_K(SNAP_K)) u_snap (
        .clk          (clk),
        .rst_n        (rst_n),
        .running      (running),
        .commit_valid (commit_valid),
        .commit_tag   (commit_tag),
        .kill_take    (kill_take),
        .live_val     (live_q),
        .last_tag     (last_tag_q),
        .last_ok      (last_ok_q),
        .cmt_val      (cmt_val),
        .cmt_tag      (cmt_owner),
        .cmt_ok       (cmt_owner_valid)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q     <= '0;
            last_tag_q <= '0;
            last_ok_q  <= 1'b0;
            kill_tag_q <= '0;
        end else begin
            if (kill_take) kill_tag_q <= kill_tag;
            if (state == ST_RESTORE) begin
                live_q     <= cmt_val;
                last_tag_q <= cmt_owner;
                last_ok_q  <= cmt_owner_valid;
            end else if (issue_fire) begin
                live_q     <= alu_nxt;
                last_tag_q <= iss_tag;
                last_ok_q  <= 1'b1;
            end else if (rep_apply) begin
                live_q     <= alu_nxt;
                last_tag_q <= rep_tag;
                last_ok_q  <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_tag   <= '0;
            res_dest  <= '0;
            res_data  <= '0;
        end else begin
            res_valid <= issue_fire;
            if (issue_fire) begin
                res_tag  <= iss_tag;
                res_dest <= iss_dest;
                res_data <= alu_nxt;
            end
        end
    end

    assert_restore_loads_committed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RESTORE) |=> (live_q == $past(cmt_val)));

    assert_result_follows_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(iss_valid && iss_ready));

    assert_silent_replay_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REPLAY) |-> !res_valid);

    assert_no_accept_when_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !res_valid);
endmodule

// File: tb/sim_spec_ctx_mgr.sv
`timescale 1ns/1ps
module sim_spec_ctx_mgr;
    localparam int DW = 8;
    localparam int QW = 4;
    localparam int K  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic iss_valid = 0, commit_valid = 0, kill_valid = 0, rep_valid = 0, rep_done = 0;
    logic [7:0] iss_tag = 0, commit_tag = 0, kill_tag = 0, rep_tag = 0;
    logic [1:0] iss_op = 0, rep_op = 0;
    logic [DW-1:0] iss_src = 0, rep_src = 0;
    logic [QW-1:0] iss_dest = 0;
    logic iss_ready, res_valid, busy, replay_start, cmt_owner_valid;
    logic [7:0] res_tag, cmt_owner;
    logic [QW-1:0] res_dest;
    logic [DW-1:0] res_data;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    spec_ctx_mgr #(.DATA_W(DW), .DEST_W(QW), .SNAP_K(K)) u0 (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_tag(iss_tag),
        .iss_op(iss_op), .iss_src(iss_src), .iss_dest(iss_dest),
        .res_valid(res_valid), .res_tag(res_tag), .res_dest(res_dest), .res_data(res_data),
        .commit_valid(commit_valid), .commit_tag(commit_tag),
        .kill_valid(kill_valid), .kill_tag(kill_tag),
        .busy(busy), .replay_start(replay_start),
        .rep_valid(rep_valid), .rep_tag(rep_tag), .rep_op(rep_op), .rep_src(rep_src),
        .rep_done(rep_done),
        .cmt_owner(cmt_owner), .cmt_owner_valid(cmt_owner_valid)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        @(negedge clk); @(negedge clk); rst_n = 1;
        @(negedge clk);
    endtask

    task automatic issue(input int tag, input int op, input int src, input int exp, input string req);
        @(negedge clk);
        iss_valid = 1; iss_tag = 8'(tag); iss_op = 2'(op); iss_src = DW'(src);
        iss_dest = QW'(tag);
        @(negedge clk);
        iss_valid = 0;
        chk(res_valid === 1'b1, {req, " res_valid"}, int'(res_valid), 1);
        chk(res_data === DW'(exp), {req, " data"}, int'(res_data), exp & 255);
        chk(res_tag === 8'(tag) && res_dest === QW'(tag), {req, " tag/dest"}, int'(res_tag), tag & 255);
        @(negedge clk);
        chk(res_valid === 1'b0, {req, " single pulse"}, int'(res_valid), 0);
    endtask

    task automatic commit(input int tag);
        @(negedge clk); commit_valid = 1; commit_tag = 8'(tag);
        @(negedge clk); commit_valid = 0;
    endtask

    task automatic kill(input int tag);
        @(negedge clk); kill_valid = 1; kill_tag = 8'(tag);
        #1 chk(iss_ready === 1'b0, "R5 ready low on kill", int'(iss_ready), 0);
        @(negedge clk); kill_valid = 0;
        chk(busy === 1'b1 && replay_start === 1'b1, "R6 restore cycle", int'({busy, replay_start}), 3);
        chk(iss_ready === 1'b0, "R8 ready low while busy", int'(iss_ready), 0);
        @(negedge clk);
        chk(busy === 1'b1 && replay_start === 1'b0, "R6 replay cycle", int'({busy, replay_start}), 2);
    endtask

    task automatic replay(input int tag, input int op, input int src);
        @(negedge clk); rep_valid = 1; rep_tag = 8'(tag); rep_op = 2'(op); rep_src = DW'(src);
        @(negedge clk); rep_valid = 0;
        chk(res_valid === 1'b0, "R7 no result in replay", int'(res_valid), 0);
    endtask

    task automatic finish_replay();
        @(negedge clk); rep_done = 1;
        @(negedge clk); rep_done = 0;
        chk(busy === 1'b0 && iss_ready === 1'b1, "R8 back to run", int'({busy, iss_ready}), 1);
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int acc;
        int t;
        // R1 reset state
        do_reset();
        chk(iss_ready === 1 && busy === 0 && replay_start === 0, "R1 control", int'({iss_ready, busy, replay_start}), 4);
        chk(res_valid === 0 && cmt_owner_valid === 0, "R1 result/owner", int'({res_valid, cmt_owner_valid}), 0);
        issue(0, 0, 0, 0, "R1 read zero");

        // R2 sweep of every op against several operands
        acc = 0; t = 1;
        for (int op = 0; op < 4; op++) begin
            for (int s = 0; s < 5; s++) begin
                int src;
                src = (s == 0) ? 0 : (s == 1) ? 1 : (s == 2) ? 127 : (s == 3) ? 255 : 200;
                case (op)
                    0: acc = acc;
                    1: acc = (acc + src) & 255;
                    2: acc = src;
                    default: acc = (src != 0) ? ((acc + 1) & 255) : acc;
                endcase
                issue(t, op, src, acc, "R2 op sweep");
                t++;
            end
        end

        // R3/R4 snapshot, owner promotion and R7 filtered replay
        do_reset();
        acc = 0;
        for (int i = 1; i <= 6; i++) begin
            acc += i;
            issue(i, 1, i, acc, "R2 add");
        end
        commit(1); commit(2); commit(3);
        chk(cmt_owner_valid === 0, "R3 snapshot not yet committed", int'(cmt_owner_valid), 0);
        commit(4); commit(5); commit(6);
        chk(cmt_owner_valid === 1 && cmt_owner === 8'd6, "R4 owner promoted", int'(cmt_owner), 6);
        issue(7, 1, 10, 31, "R2 add");
        issue(8, 1, 20, 51, "R2 add");
        issue(9, 2, 99, 99, "R2 set");
        kill(8);
        replay(6, 1, 6);
        replay(7, 1, 10);
        replay(8, 1, 20);
        replay(9, 2, 99);
        finish_replay();
        issue(10, 0, 0, 31, "R7 replay window");

        // R5 kill clears the commit counter
        commit(7); commit(10);
        issue(11, 1, 1, 32, "R2 add");
        kill(11);
        replay(7, 1, 10);
        replay(10, 0, 0);
        replay(11, 1, 1);
        finish_replay();
        issue(12, 1, 2, 33, "R5 state after rollback");
        commit(12);
        chk(cmt_owner === 8'd6, "R5 counter restarted", int'(cmt_owner), 6);

        // R7 tag wraparound with no committed owner (R6 restores zero)
        do_reset();
        issue(254, 1, 5, 5, "R2 add");
        issue(255, 1, 7, 12, "R2 add");
        issue(0, 1, 11, 23, "R2 add");
        issue(1, 1, 13, 36, "R2 add");
        kill(0);
        replay(254, 1, 5);
        replay(255, 1, 7);
        replay(0, 1, 11);
        replay(1, 1, 13);
        finish_replay();
        issue(2, 0, 0, 12, "R7 wraparound filter");

        // R4 snapshot and owner commit in the same cycle
        do_reset();
        issue(1, 1, 1, 1, "R2 add");
        issue(2, 1, 2, 3, "R2 add");
        issue(3, 1, 4, 7, "R2 add");
        commit(1); commit(2); commit(3);
        chk(cmt_owner_valid === 1 && cmt_owner === 8'd3, "R4 same-cycle match", int'(cmt_owner), 3);
        issue(4, 1, 8, 15, "R2 add");
        kill(4);
        replay(3, 1, 4);
        replay(4, 1, 8);
        finish_replay();
        issue(5, 0, 0, 7, "R6 restore from committed");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule